// File: doc/BRIEF.md
# Extended Match-Timer Bank

This block is a bank of eight match channels, numbered 4 to 11, that sit next to a system's base timer. Each channel has three registers: a counter, a match value and a control word. A counter advances on a tick strobe picked by its control word, and the five strobes arrive from outside. A channel can compare against its own counter. It can also compare against the counter at the head of its group: channel 4 heads channels 4 to 7, channel 8 heads 8 and 9, and channel 10 heads 10 and 11. A match can clear the counter it compares against. A match can fire once, or it can stay armed and fire every time the count comes round.

A match on an enabled channel sets that channel's status bit. All eight channels drive one interrupt line, which stays high while any status bit is set. Software clears status by writing ones. For channels 9 and 11, a control bit makes a read of the channel's counter also capture the count of the channel just below it into a snapshot register. Software can then read a pair of counts that were taken together.

Software reaches the bank through a simple synchronous register port. A write takes effect at the clock edge that samples it. Read data comes back one cycle after the read strobe, together with a valid flag.

Top module: `xtmr_bank`

## Requirements
- R1: After a synchronous reset, all of the following read as zero: every counter, match value, control word, enable and status bit, and the snapshot. The interrupt is low and every counter is stopped.
- R2: Control bits [2:0] select the tick source as follows. 1 selects strobe bit 0, 2 selects bit 1, 3 selects bit 2, 4 selects bit 3 and 5 selects bit 4. The values 0, 6 and 7 stop the counter. A counter advances by one at each clock edge on which its selected strobe is high.
- R3: Counter registers are at 0x40 + 4*(n-4), match registers at 0x80 + 4*(n-4) and control registers at 0xC0 + 4*(n-4), where n is the channel number. A write to a counter loads it at that edge and takes priority over a tick. Read data appears, with the valid flag, one clock after the read strobe.
- R4: A match fires at the tick that brings the selected count to equal the match value of an armed channel. Writing a match register arms the channel. A match sets status bit n (register 0x14) only if enable bit n (register 0x1C) is set.
- R5: With control bit 6 clear, a match disarms the channel until its match register is written again. With bit 6 set, the channel stays armed and fires again each time the count reaches the match value.
- R6: With control bit 3 set, the counter the channel compares against loads zero, instead of the match value, at the matching tick.
- R7: With control bit 7 set, a channel uses its own counter. With bit 7 clear, it uses the head counter of its group (4 for 4 to 7, 8 for 8 and 9, 10 for 10 and 11). A non-head channel with bit 7 clear has its own counter stopped.
- R8: Control words for channels 4 to 7 keep bits [7:0] and read back zero in bits [9:8]. Control words for channels 8 to 11 keep bits [9:0]. For channels 8 to 11, bit 8 set stops the counter.
- R9: A read of the counter of channel 9 or 11 whose control bit 9 is set copies the count of channel 8 or 10 into the snapshot register at 0x20. Otherwise a counter read leaves the snapshot unchanged.
- R10: Writing ones to status bits clears them. The interrupt output is high, from the edge that sets a status bit, until the edge at which the last status bit is cleared.
- R11: A channel whose selected counter is stopped never produces a match, whatever strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data, registered |
| rd_valid | output | 1 | High one cycle after rd_en |
| tick_src | input | 5 | Tick strobes selected by control bits [2:0] |
| irq | output | 1 | Shared interrupt for channels 4 to 11 |

## Verification
The hardest situation to reach is a match that fires on a shared counter without ever showing up as status. This happens when a second channel reads the group head's counter but is not enabled. The bench sets up channel 5 to track channel 4's counter with a lower match value, while only channel 4 is enabled. It then steps the count one strobe at a time and checks the status and interrupt at each step. The one-shot and periodic cases are reached by re-running the same count from zero, first without re-arming and then with bit 6 set.

// File: rtl/xtmr_pkg.sv
package xtmr_pkg;
  localparam int NCH   = 8;   // channels 4..11 held as index 0..7
  localparam int CH0   = 4;   // channel number of index 0 / status bit base
  localparam int CTLW  = 10;  // widest control word
  localparam int NSRC  = 5;   // tick strobes
  localparam int ADW   = 8;   // register address width
  localparam int IDXW  = $clog2(NCH);

  localparam logic [ADW-1:0] A_SNAP = 8'h20;
  localparam logic [ADW-1:0] A_STAT = 8'h14;
  localparam logic [ADW-1:0] A_IEN  = 8'h1C;
  localparam logic [2:0]     RG_CNT = 3'b010;
  localparam logic [2:0]     RG_MAT = 3'b100;
  localparam logic [2:0]     RG_CTL = 3'b110;

  localparam int B_CLR  = 3;
  localparam int B_PER  = 6;
  localparam int B_OWN  = 7;
  localparam int B_HALT = 8;
  localparam int B_SNAP = 9;

  typedef enum logic [2:0] {
    SRC_OFF = 3'd0,
    SRC_S0  = 3'd1,
    SRC_S1  = 3'd2,
    SRC_S2  = 3'd3,
    SRC_S3  = 3'd4,
    SRC_S4  = 3'd5,
    SRC_X6  = 3'd6,
    SRC_X7  = 3'd7
  } src_e;

  // index of the counter that heads the group of a channel index
  function automatic int grp_head(input int ch);
    if (ch < 4) return 0;
    else if (ch < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/xtmr_tick_sel.sv
module xtmr_tick_sel
  import xtmr_pkg::*;
#(
  parameter bit PRIMARY = 1'b1,
  parameter bit WIDE    = 1'b0
) (
  input  logic [CTLW-1:0] ctrl,
  input  logic [NSRC-1:0] strobe,
  output logic            tick
);
  src_e sel;
  logic raw;
  logic parked;
  logic halted;
  logic unused_ctl;

  assign sel        = src_e'(ctrl[2:0]);
  assign unused_ctl = ^{ctrl[B_SNAP], ctrl[B_PER:B_CLR]};

  always_comb begin
    case (sel)
      SRC_S0:  raw = strobe[0];
      SRC_S1:  raw = strobe[1];
      SRC_S2:  raw = strobe[2];
      SRC_S3:  raw = strobe[3];
      SRC_S4:  raw = strobe[4];
      default: raw = 1'b0;
    endcase
  end

  generate
    if (PRIMARY) begin : g_head
      assign parked = 1'b0;
    end else begin : g_member
      assign parked = !ctrl[B_OWN];
    end
    if (WIDE) begin : g_wide
      assign halted = ctrl[B_HALT];
    end else begin : g_narrow
      assign halted = 1'b0;
    end
  endgenerate

  assign tick = raw && !parked && !halted;
endmodule

// File: rtl/xtmr_cmp.sv
module xtmr_cmp #(
  parameter int CW = 32
) (
  input  logic [CW-1:0] cnt,
  input  logic          tick,
  input  logic [CW-1:0] match,
  input  logic          armed,
  output logic          hit
);
  logic [CW-1:0] nxt;
  assign nxt = cnt + CW'(1);
  assign hit = armed && tick && (nxt == match);
endmodule

// File: rtl/xtmr_bank.sv
module xtmr_bank
  import xtmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [ADW-1:0]  addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  input  logic [NSRC-1:0] tick_src,
  output logic            irq
);
  logic [NCH-1:0][CW-1:0]   cnt_q;
  logic [NCH-1:0][CW-1:0]   mat_q;
  logic [NCH-1:0][CTLW-1:0] ctrl_q;
  logic [NCH-1:0]           armed_q;
  logic [NCH-1:0]           stat_q;
  logic [NCH-1:0]           ien_q;
  logic [CW-1:0]            snap_q;
  logic                     irq_q;

  logic [NCH-1:0]           tick;
  logic [NCH-1:0]           sel_tick;
  logic [NCH-1:0][CW-1:0]   sel_cnt;
  logic [NCH-1:0][IDXW-1:0] src_ch;
  logic [NCH-1:0]           hit;
  logic [NCH-1:0]           clr_req;
  logic [NCH-1:0]           wr_cnt, wr_mat, wr_ctl;
  logic [NCH-1:0]           stat_d;
  logic                     is_word;
  logic [2:0]               rg;
  logic [IDXW-1:0]          idx;
  logic                     wr_stat, wr_ien;
  logic                     snap_take;
  logic [DW-1:0]            rd_mux;

  // address decode
  assign rg      = addr[7:5];
  assign idx     = addr[2 +: IDXW];
  assign is_word = (addr[1:0] == 2'b00);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_ien  = wr_en && (addr == A_IEN);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int  HEAD = grp_head(g);
      localparam bit  WIDE = (g >= 4);
      localparam logic [CTLW-1:0] KEEP = WIDE ? {CTLW{1'b1}} : CTLW'(8'hFF);

      assign wr_cnt[g] = wr_en && is_word && (rg == RG_CNT) && (idx == IDXW'(g));
      assign wr_mat[g] = wr_en && is_word && (rg == RG_MAT) && (idx == IDXW'(g));
      assign wr_ctl[g] = wr_en && is_word && (rg == RG_CTL) && (idx == IDXW'(g));

      xtmr_tick_sel #(.PRIMARY(HEAD == g), .WIDE(WIDE)) u_ts (
        .ctrl   (ctrl_q[g]),
        .strobe (tick_src),
        .tick   (tick[g])
      );

      assign src_ch[g]   = ctrl_q[g][B_OWN] ? IDXW'(g) : IDXW'(HEAD);
      assign sel_cnt[g]  = cnt_q[src_ch[g]];
      assign sel_tick[g] = tick[src_ch[g]];

      xtmr_cmp #(.CW(CW)) u_cmp (
        .cnt   (sel_cnt[g]),
        .tick  (sel_tick[g]),
        .match (mat_q[g]),
        .armed (armed_q[g]),
        .hit   (hit[g])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q[g] <= '0;
        end else if (wr_ctl[g]) begin
          ctrl_q[g] <= wdata[CTLW-1:0] & KEEP;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mat_q[g]   <= '0;
          armed_q[g] <= 1'b0;
        end else if (wr_mat[g]) begin
          mat_q[g]   <= wdata[CW-1:0];
          armed_q[g] <= 1'b1;
        end else if (hit[g] && !ctrl_q[g][B_PER]) begin
          armed_q[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[g] <= '0;
        end else if (wr_cnt[g]) begin
          cnt_q[g] <= wdata[CW-1:0];
        end else if (clr_req[g]) begin
          cnt_q[g] <= '0;
        end else if (tick[g]) begin
          cnt_q[g] <= cnt_q[g] + CW'(1);
        end
      end
    end
  endgenerate

  // clear-on-match requests routed to the counter each channel watches
  always_comb begin
    clr_req = '0;
    for (int j = 0; j < NCH; j++) begin
      if (hit[j] && ctrl_q[j][B_CLR]) clr_req[src_ch[j]] = 1'b1;
    end
  end

  // status: new matches win over a clear in the same cycle
  assign stat_d = (stat_q & ~(wr_stat ? wdata[CH0 +: NCH] : '0)) | (hit & ien_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_d;
      if (wr_ien) ien_q <= wdata[CH0 +: NCH];
    end
  end

  // snapshot: reading the odd member of a two-channel group grabs its head
  assign snap_take = rd_en && is_word && (rg == RG_CNT) && idx[IDXW-1] && idx[0]
                     && ctrl_q[idx][B_SNAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
    end else if (snap_take) begin
      snap_q <= cnt_q[idx - IDXW'(1)];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_SNAP) begin
      rd_mux = DW'(snap_q);
    end else if (addr == A_STAT) begin
      rd_mux[CH0 +: NCH] = stat_q;
    end else if (addr == A_IEN) begin
      rd_mux[CH0 +: NCH] = ien_q;
    end else if (is_word) begin
      case (rg)
        RG_CNT:  rd_mux = DW'(cnt_q[idx]);
        RG_MAT:  rd_mux = DW'(mat_q[idx]);
        RG_CTL:  rd_mux = DW'(ctrl_q[idx]);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/xtmr_bank_chk.sv
module xtmr_bank_chk
  import xtmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADW-1:0]           addr,
  input logic [DW-1:0]            wdata,
  input logic                     irq,
  input logic [NCH-1:0]           stat_q,
  input logic [NCH-1:0]           ien_q,
  input logic [NCH-1:0][CW-1:0]   cnt_q,
  input logic [NCH-1:0][CTLW-1:0] ctrl_q
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && stat_q == '0));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q != '0 && !(wr_en && addr == A_STAT)) |=> irq);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_c
      localparam logic [ADW-1:0] CA = ADW'(8'h40 + 4 * g);

      // R3
      cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CA) |=> cnt_q[g] == $past(wdata[CW-1:0]));

      // R11
      stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[g][2:0] == 3'd0 && !(wr_en && addr == CA)) |=> $stable(cnt_q[g]));

      // R4
      masked_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (!ien_q[g] && !stat_q[g]) |=> !stat_q[g]);
    end
  endgenerate
endmodule

bind xtmr_bank xtmr_bank_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .irq    (irq),
  .stat_q (stat_q),
  .ien_q  (ien_q),
  .cnt_q  (cnt_q),
  .ctrl_q (ctrl_q)
);

// File: tb/sim_xtmr_bank.sv
module sim_xtmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [4:0]  tick_src = '0;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  xtmr_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .tick_src(tick_src), .irq(irq)
  );

  function automatic logic [7:0] a_cnt(input int ch); return 8'(8'h40 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_mat(input int ch); return 8'(8'h80 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_ctl(input int ch); return 8'(8'hC0 + 4 * (ch - 4)); endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push the expected value, then issue the read
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick_src = m;
      @(negedge clk);
      tick_src = '0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected read actual=%08h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s read actual=%08h expected=%08h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(a_ctl(4), 32'h0, "R1 ctl4");
    rd(a_cnt(4), 32'h0, "R1 cnt4");
    rd(8'h14, 32'h0, "R1 status");
    // R11 stopped counters ignore all strobes
    pulse(5'h1F, 3);
    rd(a_cnt(4), 32'h0, "R11 cnt4 stopped");
    rd(a_cnt(8), 32'h0, "R11 cnt8 stopped");

    // R2 source select
    wr(a_ctl(4), 32'h1);
    pulse(5'h01, 3);
    pulse(5'h02, 2);
    rd(a_cnt(4), 32'd3, "R2 src1");
    wr(a_ctl(4), 32'h4);
    pulse(5'h08, 2);
    pulse(5'h01, 1);
    rd(a_cnt(4), 32'd5, "R2 src4");
    wr(a_ctl(4), 32'h5);
    pulse(5'h10, 1);
    rd(a_cnt(4), 32'd6, "R2 src5");
    wr(a_ctl(4), 32'h7);
    pulse(5'h1F, 2);
    rd(a_cnt(4), 32'd6, "R2 src7 stopped");

    // R3 counter load
    wr(a_cnt(4), 32'd100);
    rd(a_cnt(4), 32'd100, "R3 load");

    // R8 control widths and halt bit
    wr(a_ctl(5), 32'h3FF);
    rd(a_ctl(5), 32'h0FF, "R8 narrow");
    wr(a_ctl(8), 32'h3FF);
    rd(a_ctl(8), 32'h3FF, "R8 wide");
    wr(a_ctl(8), 32'h181);
    wr(a_cnt(8), 32'd7);
    pulse(5'h01, 2);
    rd(a_cnt(8), 32'd7, "R8 halt");

    // R4 / R10 enabled vs masked match on a shared counter
    wr(a_ctl(4), 32'h01);
    wr(a_ctl(5), 32'h00);
    wr(8'h1C, 32'h010);
    wr(a_cnt(4), 32'd0);
    wr(a_mat(4), 32'd3);
    wr(a_mat(5), 32'd2);
    pulse(5'h01, 2);
    chk_irq(1'b0, "R4 masked ch5");
    rd(8'h14, 32'h0, "R4 masked status");
    pulse(5'h01, 1);
    chk_irq(1'b1, "R10 raise");
    rd(8'h14, 32'h010, "R4 status ch4");
    wr(8'h14, 32'h020);
    chk_irq(1'b1, "R10 other bit");
    wr(8'h14, 32'h010);
    chk_irq(1'b0, "R10 cleared");

    // R5 one-shot: no refire without re-arm
    wr(a_cnt(4), 32'd0);
    pulse(5'h01, 3);
    rd(8'h14, 32'h0, "R5 one-shot");

    // R6 / R5 periodic with clear on match
    wr(a_ctl(4), 32'h49);
    wr(a_mat(4), 32'd3);
    wr(a_cnt(4), 32'd0);
    pulse(5'h01, 3);
    chk_irq(1'b1, "R6 match");
    rd(a_cnt(4), 32'd0, "R6 cleared");
    wr(8'h14, 32'h010);
    chk_irq(1'b0, "R10 cleared again");
    pulse(5'h01, 3);
    chk_irq(1'b1, "R5 periodic refire");
    wr(8'h14, 32'h010);
    wr(a_ctl(4), 32'h0);

    // R7 own counter, and a parked non-head counter
    wr(8'h1C, 32'h040);
    wr(a_ctl(6), 32'h81);
    wr(a_cnt(6), 32'd0);
    wr(a_mat(6), 32'd2);
    pulse(5'h01, 2);
    chk_irq(1'b1, "R7 own match");
    rd(8'h14, 32'h040, "R7 status ch6");
    wr(8'h14, 32'h040);
    wr(a_ctl(7), 32'h01);
    wr(a_cnt(7), 32'd5);
    pulse(5'h01, 2);
    rd(a_cnt(7), 32'd5, "R7 parked");

    // R9 snapshot
    wr(a_ctl(8), 32'h001);
    wr(a_cnt(8), 32'd0);
    pulse(5'h01, 4);
    wr(a_ctl(9), 32'h200);
    wr(a_cnt(9), 32'd9);
    rd(a_cnt(9), 32'd9, "R9 cnt9");
    rd(8'h20, 32'd4, "R9 snap8");
    wr(a_ctl(11), 32'h000);
    wr(a_cnt(10), 32'd55);
    rd(a_cnt(11), 32'd0, "R9 cnt11");
    rd(8'h20, 32'd4, "R9 no capture");
    wr(a_ctl(11), 32'h200);
    rd(a_cnt(11), 32'd0, "R9 cnt11 b");
    rd(8'h20, 32'd55, "R9 snap10");

    // R11 stopped counter never matches
    wr(8'h1C, 32'h400);
    wr(a_ctl(10), 32'h0);
    wr(a_cnt(10), 32'd0);
    wr(a_mat(10), 32'd1);
    pulse(5'h1F, 2);
    chk_irq(1'b0, "R11 no match");
    rd(8'h14, 32'h0, "R11 status");

    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule